// File: doc/BRIEF.md
# Multi-Target SPI Mode-0 Byte Master

This block is a byte-wide serial master for SPI mode 0. It runs from a fast system clock and produces the serial clock by counting system cycles, so the serial clock idles low, new output data is placed on the line at each falling edge, and input data is captured at each rising edge. A user-side producer hands over one byte at a time through a valid/ready handshake. Each byte comes with a target index and a flag that marks the final byte of a burst.

The target index drives exactly one of several active-low select lines low. The line stays low across consecutive bytes of a burst and goes high only after the byte that carried the final flag. Every byte received from the target appears on the output bus with a single-cycle strobe.

Parameters give the system clock rate, the serial clock rate and the number of targets. The serial clock rate must be at most one tenth of the system rate.

Top module: `spim_master`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the block returns to idle. After that edge every bit of `spi_cs_n` is high, `spi_sclk` is low, `in_ready` is high and `out_vld` is low.
- R2: Each high and each low phase of `spi_sclk` inside a byte lasts HALF system cycles, with HALF = round(SYS_HZ / (2 × SCLK_HZ)). When no byte is being shifted, `spi_sclk` rests low.
- R3: The 8 bits of `in_data` go out on `spi_mosi` most significant bit first. `spi_mosi` changes only at falling edges of `spi_sclk` and holds steady while `spi_sclk` is high.
- R4: `spi_miso` is sampled at each rising edge of `spi_sclk`, most significant bit first. After the eighth bit, the byte appears on `out_data` while `out_vld` is high for exactly one cycle, once per transferred byte.
- R5: A byte is accepted in a cycle where `in_vld` and `in_ready` are both high. `in_ready` stays low from the cycle after acceptance until that byte has finished, and it is always low while `spi_sclk` is high.
- R6: `in_addr` is a binary index. Value i drives only `spi_cs_n[i]` low, and no two select lines are ever low together. The index is taken from the first byte of a burst, and `in_addr` on later bytes of the same burst has no effect.
- R7: After a byte accepted with `in_last` = 0, the select line stays low, with `spi_sclk` low, until the next byte. After a byte accepted with `in_last` = 1, all select lines return high.
- R8: The select line is low for at least HALF system cycles before the first rising edge of a burst and for at least HALF system cycles after its last falling edge. `spi_sclk` is never high while all select lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Byte offered on `in_data` |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | 8 | Byte to transmit |
| in_addr | input | AW | Target index, AW = ceil(log2(TARGETS)) (at least 1) |
| in_last | input | 1 | Byte ends the burst |
| out_data | output | 8 | Byte received from the target |
| out_vld | output | 1 | One-cycle strobe: `out_data` holds a new byte |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |
| spi_cs_n | output | TARGETS | Active-low select, one line per target |

## Verification
The hardest case to reach is the gap inside a burst. There the handshake is idle and ready is high, but the select line must stay low and the latched target must survive a change on the address input. The stimulus opens a burst, waits until the block returns ready, and then sits idle for many cycles while it checks the select lines. It then sends the next byte with a different address, and the select pattern must still name the original target. A bench target model shifts distinct response bytes back, including all-zero and all-one bytes, so that bit order and capture edges show up in the scoreboard.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
// spim_pkg: shared types and helper functions for the SPI mode-0 master.
// Assumes: frequencies are given in Hz and fit a 32-bit signed integer.
package spim_pkg;

    // Controller phases: waiting for a byte, shifting it, closing a burst.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TRAIL = 2'd2
    } spim_state_e;

    // Rounded number of system cycles in half a serial-clock period.
    function automatic int half_cycles(input int sys_hz, input int sclk_hz);
        return (sys_hz + sclk_hz) / (2 * sclk_hz);
    endfunction

endpackage

// File: rtl/spim_half_tick.sv
`timescale 1ns/1ps
// spim_half_tick: while run is high, pulses tick once every HALF cycles.
// The first tick comes HALF cycles after run rises. Dropping run clears
// the count at once. Assumes HALF >= 1.
module spim_half_tick #(
    parameter int HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF - 1));

    // Counts system cycles inside the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: ticks never come back to back when the half period is longer than one cycle
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (HALF > 1 && tick) |=> !tick);

endmodule

// File: rtl/spim_shifter.sv
`timescale 1ns/1ps
// spim_shifter: transmit and receive shift registers, MSB first.
// load copies a new word into the transmit register. fall moves the next
// bit onto the output. rise captures one input bit. Assumes load never
// comes in the same cycle as rise or fall.
module spim_shifter #(
    parameter int WORD = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WORD-1:0] load_data,
    input  logic            rise,
    input  logic            fall,
    input  logic            ser_in,
    output logic            ser_out,
    output logic [WORD-1:0] rx_word
);
    logic [WORD-1:0] tx_q;
    logic [WORD-1:0] rx_q;

    // Transmit register: loaded on accept, moved left on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_data;
        end else if (fall) begin
            tx_q <= {tx_q[WORD-2:0], 1'b0};
        end
    end

    // Receive register: takes one input bit on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (rise) begin
            rx_q <= {rx_q[WORD-2:0], ser_in};
        end
    end

    assign ser_out = tx_q[WORD-1];
    assign rx_word = rx_q;

    // R3: the output bit moves only at a falling edge or a load
    p_out_moves_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(fall) && !$past(load)) |-> $stable(ser_out));

endmodule

// File: rtl/spim_cs_decode.sv
`timescale 1ns/1ps
// spim_cs_decode: turns a binary target index into active-low select lines.
// While en is high, only the line that matches sel goes low. While en is
// low, all lines are high.
module spim_cs_decode #(
    parameter int TARGETS = 4,
    parameter int AW      = 2
) (
    input  logic               en,
    input  logic [AW-1:0]      sel,
    output logic [TARGETS-1:0] cs_n
);
    // One comparator per select line.
    for (genvar g = 0; g < TARGETS; g++) begin : g_line
        assign cs_n[g] = !(en && (sel == AW'(g)));
    end

endmodule

// File: rtl/spim_master.sv
`timescale 1ns/1ps
// spim_master: byte-wide SPI mode-0 master driving several targets.
// The serial clock comes from counting system cycles. One byte is accepted
// per valid/ready handshake. The target index is latched on the first byte
// of a burst, and the select line is released after a byte flagged last.
// Assumes SCLK_HZ <= SYS_HZ / 10 and TARGETS >= 1.
module spim_master #(
    parameter int SYS_HZ  = 200_000_000,
    parameter int SCLK_HZ = 10_000_000,
    parameter int TARGETS = 4,
    parameter int WORD    = 8,
    parameter int AW      = (TARGETS > 1) ? $clog2(TARGETS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_vld,
    output logic               in_ready,
    input  logic [WORD-1:0]    in_data,
    input  logic [AW-1:0]      in_addr,
    input  logic               in_last,
    output logic [WORD-1:0]    out_data,
    output logic               out_vld,
    output logic               spi_sclk,
    output logic               spi_mosi,
    input  logic               spi_miso,
    output logic [TARGETS-1:0] spi_cs_n
);
    import spim_pkg::*;

    localparam int HALF  = half_cycles(SYS_HZ, SCLK_HZ);
    localparam int EDGES = 2 * WORD;
    localparam int EW    = $clog2(EDGES);

    spim_state_e   st;
    logic          burst_open;
    logic [AW-1:0] addr_q;
    logic          last_q;
    logic [EW-1:0] edge_cnt;
    logic          sclk_q;
    logic          vld_q;
    logic          tick;
    logic          accept;
    logic          rise;
    logic          fall;
    logic          byte_end;

    assign accept   = in_vld && (st == ST_IDLE);
    assign rise     = tick && (st == ST_SHIFT) && !sclk_q;
    assign fall     = tick && (st == ST_SHIFT) && sclk_q;
    assign byte_end = fall && (edge_cnt == EW'(EDGES - 1));

    spim_half_tick #(.HALF(HALF)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st != ST_IDLE),
        .tick  (tick)
    );

    spim_shifter #(.WORD(WORD)) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (in_data),
        .rise      (rise),
        .fall      (fall),
        .ser_in    (spi_miso),
        .ser_out   (spi_mosi),
        .rx_word   (out_data)
    );

    spim_cs_decode #(.TARGETS(TARGETS), .AW(AW)) cs_i (
        .en   (burst_open),
        .sel  (addr_q),
        .cs_n (spi_cs_n)
    );

    // Phase control: accept, shift sixteen edges, optionally close the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            sclk_q   <= 1'b0;
            edge_cnt <= '0;
            last_q   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        st       <= ST_SHIFT;
                        last_q   <= in_last;
                        edge_cnt <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sclk_q   <= !sclk_q;
                        edge_cnt <= edge_cnt + 1'b1;
                        if (byte_end) begin
                            st <= last_q ? ST_TRAIL : ST_IDLE;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Burst framing: open on the first accept, close after the trailing gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_open <= 1'b0;
            addr_q     <= '0;
        end else if (accept && !burst_open) begin
            burst_open <= 1'b1;
            addr_q     <= in_addr;
        end else if (st == ST_TRAIL && tick) begin
            burst_open <= 1'b0;
        end
    end

    // Receive strobe: one cycle, raised together with the final falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else begin
            vld_q <= byte_end;
        end
    end

    assign in_ready = (st == ST_IDLE);
    assign spi_sclk = sclk_q;
    assign out_vld  = vld_q;

    // R6: never more than one select line low
    p_one_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));

    // R6: the latched target does not change inside a burst
    p_target_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_open && $past(burst_open)) |-> $stable(addr_q));

    // R5: the block is busy whenever the serial clock is high
    p_busy_when_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !in_ready);

    // R4: the receive strobe lasts a single cycle
    p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld);

    // R3: output data holds steady through a high phase
    p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R8: the serial clock only runs under an asserted select
    p_clock_inside_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> (spi_cs_n != '1));

endmodule

// File: tb/spim_master_tb.sv
`timescale 1ns/1ps
// spim_master_tb_top: scoreboard bench. A driver task queues the expected
// serial output and response bytes. A target model shifts bytes in both
// directions, and monitors compare what the block produces.
module spim_master_tb_top;

    localparam int SYS_HZ  = 200_000_000;
    localparam int SCLK_HZ = 10_000_000;
    localparam int TARGETS = 4;
    localparam int AW      = 2;
    localparam int HALF    = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_vld = 1'b0;
    logic               in_ready;
    logic [7:0]         in_data = 8'h00;
    logic [AW-1:0]      in_addr = '0;
    logic               in_last = 1'b0;
    logic [7:0]         out_data;
    logic               out_vld;
    logic               spi_sclk;
    logic               spi_mosi;
    logic               miso_r = 1'b0;
    logic [TARGETS-1:0] spi_cs_n;

    always #2.5 clk = ~clk;

    spim_master #(.SYS_HZ(SYS_HZ), .SCLK_HZ(SCLK_HZ), .TARGETS(TARGETS)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ready(in_ready),
        .in_data(in_data), .in_addr(in_addr), .in_last(in_last),
        .out_data(out_data), .out_vld(out_vld), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(miso_r), .spi_cs_n(spi_cs_n)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_mosi_q[$];
    logic [7:0] tgt_q[$];
    logic [7:0] exp_dout_q[$];
    int exp_tgt = 0;
    bit tb_open = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Target model: captures MOSI on rising edges, drives MISO MSB first.
    int         k = 0;
    bit         have = 0;
    logic [7:0] cur = 8'h00;
    logic [7:0] sh = 8'h00;
    always @(posedge spi_sclk) begin
        sh = {sh[6:0], spi_mosi};
        k++;
        if (k == 8) begin
            if (exp_mosi_q.size() > 0) begin
                logic [7:0] e;
                e = exp_mosi_q.pop_front();
                chk(sh == e, "R3", "serial byte at target", int'(sh), int'(e));
            end else begin
                chk(0, "R3", "unexpected serial byte", int'(sh), 0);
            end
            k = 0;
            have = 0;
        end
    end

    // MISO drive, updated between system edges, well before the next rise.
    always @(negedge clk) begin
        if (!have && tgt_q.size() > 0 && !spi_sclk) begin
            cur = tgt_q.pop_front();
            have = 1;
        end
        miso_r = cur[7 - k];
    end

    // Monitor: timing, select pattern, handshake and received bytes.
    int   hi_cnt = 0;
    int   lead = 0;
    int   trail = 0;
    bit   seen_rise = 0;
    bit   trail_on = 0;
    bit   prev_vld = 0;
    logic m0 = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_sclk) begin
                hi_cnt++;
                if (hi_cnt == 1) begin
                    m0 = spi_mosi;
                    chk(!in_ready, "R5", "ready while clock high", int'(in_ready), 0);
                    chk(spi_cs_n == ~(4'b0001 << exp_tgt), "R6", "select pattern",
                        int'(spi_cs_n), int'(~(4'b0001 << exp_tgt)));
                    if (!seen_rise) begin
                        chk(lead >= HALF, "R8", "lead before first rise", lead, HALF);
                        seen_rise = 1;
                    end
                end
                if (hi_cnt == HALF) begin
                    chk(spi_mosi == m0, "R3", "mosi steady while high",
                        int'(spi_mosi), int'(m0));
                end
                trail = 0;
                trail_on = 1;
            end else if (hi_cnt > 0) begin
                chk(hi_cnt == HALF, "R2", "high phase length", hi_cnt, HALF);
                hi_cnt = 0;
            end
            if (spi_cs_n == '1) begin
                chk(!spi_sclk, "R8", "clock with no select", int'(spi_sclk), 0);
                if (trail_on) begin
                    chk(trail >= HALF, "R8", "trail after last fall", trail, HALF);
                    trail_on = 0;
                end
                lead = 0;
                seen_rise = 0;
            end else if (!spi_sclk) begin
                if (!seen_rise) lead++;
                if (trail_on) trail++;
            end
            if (out_vld) begin
                chk(!prev_vld, "R4", "strobe longer than one cycle", 1, 0);
                if (exp_dout_q.size() > 0) begin
                    logic [7:0] e;
                    e = exp_dout_q.pop_front();
                    chk(out_data == e, "R4", "received byte", int'(out_data), int'(e));
                end else begin
                    chk(0, "R4", "unexpected strobe", int'(out_data), 0);
                end
            end
            prev_vld = out_vld;
        end
    end

    // Driver: queues expectations, then offers one byte through the handshake.
    task automatic send(input int addr, input logic [7:0] data,
                        input bit last, input logic [7:0] resp);
        while (!in_ready) @(negedge clk);
        if (!tb_open) begin
            exp_tgt = addr;
            tb_open = 1;
        end
        exp_mosi_q.push_back(data);
        tgt_q.push_back(resp);
        exp_dout_q.push_back(resp);
        in_addr = AW'(addr);
        in_data = data;
        in_last = last;
        in_vld  = 1'b1;
        @(negedge clk);
        in_vld  = 1'b0;
        in_data = ~data;
        in_addr = ~in_addr;
        chk(!in_ready, "R5", "ready after accept", int'(in_ready), 0);
        if (last) tb_open = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", "run did not finish", 0, 1);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: state after reset
        chk(spi_cs_n == '1, "R1", "select lines after reset", int'(spi_cs_n), 15);
        chk(!spi_sclk, "R1", "sclk after reset", int'(spi_sclk), 0);
        chk(in_ready, "R1", "ready after reset", int'(in_ready), 1);
        chk(!out_vld, "R1", "strobe after reset", int'(out_vld), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        // R2: idle clock rests low without a byte
        chk(!spi_sclk && spi_cs_n == '1, "R2", "idle lines", int'(spi_sclk), 0);

        // Single byte to target 0
        send(0, 8'hA5, 1'b1, 8'h3C);
        wait_idle();
        chk(spi_cs_n == '1, "R7", "released after last byte", int'(spi_cs_n), 15);

        // Burst of three to target 2, address changed on later bytes
        send(2, 8'h00, 1'b0, 8'hFF);
        wait_idle();
        chk(spi_cs_n == 4'b1011, "R7", "held between bytes", int'(spi_cs_n), 11);
        repeat (40) @(negedge clk);
        chk(spi_cs_n == 4'b1011 && !spi_sclk, "R7", "held during long gap",
            int'(spi_cs_n), 11);
        send(1, 8'hFF, 1'b0, 8'h00);
        wait_idle();
        chk(spi_cs_n == 4'b1011, "R6", "later address ignored", int'(spi_cs_n), 11);
        send(0, 8'h5A, 1'b1, 8'h81);
        wait_idle();
        chk(spi_cs_n == '1, "R7", "burst closed", int'(spi_cs_n), 15);

        // Single bytes to target 3 and back-to-back burst to target 1
        send(3, 8'h80, 1'b1, 8'h01);
        send(1, 8'h01, 1'b0, 8'h80);
        send(1, 8'hC3, 1'b1, 8'h96);
        wait_idle();
        repeat (50) @(negedge clk);
        chk(exp_mosi_q.size() == 0, "R3", "serial bytes outstanding",
            exp_mosi_q.size(), 0);
        chk(exp_dout_q.size() == 0, "R4", "received bytes outstanding",
            exp_dout_q.size(), 0);
        chk(spi_cs_n == '1 && !spi_sclk, "R8", "lines at end", int'(spi_cs_n), 15);
        finish_run();
    end

endmodule